// File: doc/BRIEF.md
# Converter Code to Volts Text Formatter

This block turns an 8-bit offset-binary converter reading into a line of ASCII text that gives the measured voltage in volts with three decimals. The reading covers a bipolar span of minus five to plus five volts. All arithmetic is in integer millivolts. A start strobe captures the code. The block scales the code to a signed millivolt value and splits the magnitude into decimal digits over several cycles, using repeated subtraction rather than a divider. It then emits the text one byte at a time on a valid/ready stream. That stream can feed a serial transmitter directly.

Each line has a fixed width of fifteen characters. It holds a sign character, a zero-padded two-digit integer part, a decimal point, three fractional digits, a space, the unit word and a CR/LF pair. When the last byte has been taken, the block pulses a done flag and becomes ready for the next code.

Top module: `volt_text_fmt`

## Requirements
- R1: While reset is asserted, and after it until a start is accepted, `out_valid` and `done` are low.
- R2: The value shown in millivolts is floor(code*10000/256) - 5000. This gives code 0x00 = -5.000, code 0x80 = 00.000, code 0x7F = -0.040 and code 0xFF = 04.960.
- R3: A line is exactly 15 bytes in this order: sign, '0' (0x30), units digit, '.' (0x2E), tenths, hundredths, thousandths, space (0x20), 'V','o','l','t','s', CR (0x0D), LF (0x0A). Digits are ASCII 0x30 to 0x39.
- R4: The sign byte is '-' (0x2D) when the millivolt value is negative. It is a space (0x20) otherwise, and this includes zero.
- R5: A byte is consumed only in a cycle where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_char` does not change.
- R6: `done` is high for exactly one cycle. That cycle directly follows the clock edge that consumed the LF byte, and `out_valid` is low in it.
- R7: `code` is sampled in the cycle a start is accepted. A `start` pulse is ignored from that cycle up to and including the `done` cycle. An ignored pulse does not change the line being sent and does not cause another line to follow.
- R8: The decimal digits come from a multi-cycle repeated-subtraction unit. `out_valid` stays low until all digits of the line are known.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin formatting the code present on `code` |
| code | input | 8 | Offset-binary converter reading |
| out_ready | input | 1 | Downstream accepts the current byte |
| out_char | output | 8 | ASCII byte of the line |
| out_valid | output | 1 | `out_char` holds a byte to be taken |
| done | output | 1 | One-cycle pulse after the final byte is taken |

## Verification
The bench runs the two span ends, the mid-scale code (zero must carry a space and not a minus sign) and a code just below mid-scale. A wrong offset or wrong rounding would show there as a sign error or a digit off by one. Each code is run under several ready patterns, including a long initial stall and alternate-cycle stalls. A design that advances on valid alone would drop or repeat bytes, and one that lets the byte drift while stalled would corrupt the line. A second start arrives with a different code in the middle of a line. A design that accepts it would change digits or send a second line after done.

// File: rtl/volt_fmt_pkg.sv
package volt_fmt_pkg;

  typedef enum logic {
    DG_IDLE = 1'b0,
    DG_RUN  = 1'b1
  } dig_state_e;

  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;

  localparam logic [7:0] ASC_ZERO  = 8'h30;
  localparam logic [7:0] ASC_MINUS = 8'h2D;
  localparam logic [7:0] ASC_SPACE = 8'h20;
  localparam logic [7:0] ASC_POINT = 8'h2E;
  localparam logic [7:0] ASC_CR    = 8'h0D;
  localparam logic [7:0] ASC_LF    = 8'h0A;
  localparam int         TAIL_LEN  = 8;

  function automatic int pow10(input int n);
    int r;
    r = 1;
    for (int i = 0; i < n; i++) r = r * 10;
    return r;
  endfunction

  // Space, unit word, then line ending.
  function automatic logic [7:0] tail_char(input int k);
    logic [7:0] c;
    case (k)
      0:       c = ASC_SPACE;
      1:       c = 8'h56;
      2:       c = 8'h6F;
      3:       c = 8'h6C;
      4:       c = 8'h74;
      5:       c = 8'h73;
      6:       c = ASC_CR;
      default: c = ASC_LF;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/volt_fmt_scale.sv
module volt_fmt_scale #(
  parameter int CODE_W    = 8,
  parameter int SPAN_MV   = 10000,
  parameter int OFFSET_MV = 5000,
  parameter int MAG_W     = 14
) (
  input  logic [CODE_W-1:0] code_i,
  output logic              neg_o,
  output logic [MAG_W-1:0]  mag_o
);

  localparam int PROD_W = CODE_W + $clog2(SPAN_MV + 1);

  logic [PROD_W-1:0] prod;
  logic [PROD_W-1:0] scaled;
  logic [PROD_W-1:0] offs;
  logic [PROD_W-1:0] diff;

  always_comb begin
    prod   = PROD_W'(code_i) * PROD_W'(SPAN_MV);
    scaled = prod >> CODE_W;
    offs   = PROD_W'(OFFSET_MV);
    if (scaled < offs) begin
      neg_o = 1'b1;
      diff  = offs - scaled;
    end else begin
      neg_o = 1'b0;
      diff  = scaled - offs;
    end
    mag_o = MAG_W'(diff);
  end

endmodule

// File: rtl/volt_fmt_digits.sv
module volt_fmt_digits
  import volt_fmt_pkg::*;
#(
  parameter int MAG_W   = 14,
  parameter int NUM_DIG = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [MAG_W-1:0]        mag_i,
  output logic [NUM_DIG-1:0][3:0] digits_o,
  output logic                    fin_o
);

  localparam int POS_W = (NUM_DIG > 2) ? $clog2(NUM_DIG) : 1;

  dig_state_e               st_q, st_d;
  logic [MAG_W-1:0]         rem_q, rem_d;
  logic [POS_W-1:0]         pos_q, pos_d;
  logic [3:0]               cnt_q, cnt_d;
  logic [NUM_DIG-1:0][3:0]  dig_q, dig_d;
  logic                     fin_q, fin_d;
  logic [MAG_W-1:0]         weight;
  logic                     work_en;

  always_comb begin
    weight  = MAG_W'(pow10(int'(pos_q)));
    st_d    = st_q;
    rem_d   = rem_q;
    pos_d   = pos_q;
    cnt_d   = cnt_q;
    dig_d   = dig_q;
    fin_d   = 1'b0;
    work_en = 1'b0;
    case (st_q)
      DG_IDLE: begin
        if (load_i) begin
          work_en = 1'b1;
          st_d    = DG_RUN;
          rem_d   = mag_i;
          pos_d   = POS_W'(NUM_DIG - 1);
          cnt_d   = 4'd0;
        end
      end
      default: begin
        work_en = 1'b1;
        if (rem_q >= weight) begin
          rem_d = rem_q - weight;
          cnt_d = cnt_q + 4'd1;
        end else begin
          dig_d[pos_q] = cnt_q;
          cnt_d        = 4'd0;
          if (pos_q == POS_W'(1)) begin
            dig_d[0] = 4'(rem_q);
            st_d     = DG_IDLE;
            fin_d    = 1'b1;
          end else begin
            pos_d = pos_q - POS_W'(1);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= DG_IDLE;
      rem_q <= '0;
      pos_q <= '0;
      cnt_q <= '0;
      dig_q <= '0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= fin_d;
      if (work_en) begin
        st_q  <= st_d;
        rem_q <= rem_d;
        pos_q <= pos_d;
        cnt_q <= cnt_d;
        dig_q <= dig_d;
      end
    end
  end

  assign digits_o = dig_q;
  assign fin_o    = fin_q;

endmodule

// File: rtl/volt_fmt_stream.sv
module volt_fmt_stream
  import volt_fmt_pkg::*;
#(
  parameter int NUM_DIG  = 4,
  parameter int FRAC_DIG = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go_i,
  input  logic                    neg_i,
  input  logic [NUM_DIG-1:0][3:0] digits_i,
  input  logic                    ready_i,
  output logic [7:0]              char_o,
  output logic                    valid_o,
  output logic                    done_o
);

  localparam int INT_DIG = NUM_DIG - FRAC_DIG;
  localparam int P_INT0  = 2;
  localparam int P_POINT = P_INT0 + INT_DIG;
  localparam int P_FRAC0 = P_POINT + 1;
  localparam int P_TAIL  = P_FRAC0 + FRAC_DIG;
  localparam int LEN     = P_TAIL + TAIL_LEN;
  localparam int IDX_W   = $clog2(LEN);

  tx_state_e        st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             done_q, done_d;
  logic             step_en;
  int               p;

  always_comb begin
    st_d    = st_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    step_en = 1'b0;
    case (st_q)
      TX_IDLE: begin
        if (go_i) begin
          step_en = 1'b1;
          st_d    = TX_SEND;
          idx_d   = '0;
        end
      end
      default: begin
        if (ready_i) begin
          step_en = 1'b1;
          if (idx_q == IDX_W'(LEN - 1)) begin
            st_d   = TX_IDLE;
            done_d = 1'b1;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
    endcase
  end

  always_comb begin
    p = int'(idx_q);
    if (p == 0)
      char_o = neg_i ? ASC_MINUS : ASC_SPACE;
    else if (p < P_INT0)
      char_o = ASC_ZERO;
    else if (p < P_POINT)
      char_o = ASC_ZERO | {4'd0, digits_i[NUM_DIG - 1 - (p - P_INT0)]};
    else if (p == P_POINT)
      char_o = ASC_POINT;
    else if (p < P_TAIL)
      char_o = ASC_ZERO | {4'd0, digits_i[FRAC_DIG - 1 - (p - P_FRAC0)]};
    else
      char_o = tail_char(p - P_TAIL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= TX_IDLE;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (step_en) begin
        st_q  <= st_d;
        idx_q <= idx_d;
      end
    end
  end

  assign valid_o = (st_q == TX_SEND);
  assign done_o  = done_q;

endmodule

// File: rtl/volt_text_fmt.sv
module volt_text_fmt #(
  parameter int CODE_W      = 8,
  parameter int SPAN_MV     = 10000,
  parameter int OFFSET_MV   = 5000,
  parameter int FRAC_DIG    = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] code,
  input  logic              out_ready,
  output logic [7:0]        out_char,
  output logic              out_valid,
  output logic              done
);

  localparam int MAG_W   = $clog2(SPAN_MV + 1);
  localparam int NUM_DIG = FRAC_DIG + 1;

  logic [SYNC_STAGES-1:0]  rst_pipe;
  logic                    rst_n_s;
  logic                    busy_q, busy_d;
  logic                    neg_q;
  logic                    accept;
  logic                    neg_w;
  logic [MAG_W-1:0]        mag_w;
  logic [NUM_DIG-1:0][3:0] digits_w;
  logic                    fin_w;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_rst_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe[s] <= 1'b0;
        else if (s == 0) rst_pipe[s] <= 1'b1;
        else rst_pipe[s] <= rst_pipe[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate
  assign rst_n_s = rst_pipe[SYNC_STAGES-1];

  assign accept = start & ~busy_q;

  always_comb begin
    busy_d = busy_q;
    if (accept)    busy_d = 1'b1;
    else if (done) busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q <= 1'b0;
      neg_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      if (accept) neg_q <= neg_w;
    end
  end

  volt_fmt_scale #(
    .CODE_W(CODE_W), .SPAN_MV(SPAN_MV), .OFFSET_MV(OFFSET_MV), .MAG_W(MAG_W)
  ) i_scale (
    .code_i(code), .neg_o(neg_w), .mag_o(mag_w)
  );

  volt_fmt_digits #(
    .MAG_W(MAG_W), .NUM_DIG(NUM_DIG)
  ) i_digits (
    .clk(clk), .rst_n(rst_n_s), .load_i(accept), .mag_i(mag_w),
    .digits_o(digits_w), .fin_o(fin_w)
  );

  volt_fmt_stream #(
    .NUM_DIG(NUM_DIG), .FRAC_DIG(FRAC_DIG)
  ) i_stream (
    .clk(clk), .rst_n(rst_n_s), .go_i(fin_w), .neg_i(neg_q),
    .digits_i(digits_w), .ready_i(out_ready),
    .char_o(out_char), .valid_o(out_valid), .done_o(done)
  );

endmodule

// File: rtl/volt_text_fmt_chk.sv
module volt_text_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [7:0] code,
  input logic       out_ready,
  input logic [7:0] out_char,
  input logic       out_valid,
  input logic       done
);

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_char))); // R5

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid); // R6

  AST_DONE_AFTER_LF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(out_valid && out_ready && (out_char == 8'h0A))); // R3

  AST_CHAR_PRINTABLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_char < 8'h7F)); // R3

  AST_NO_RESTART_MIDLINE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> !done); // R7

endmodule

bind volt_text_fmt volt_text_fmt_chk i_chk (.*);

// File: tb/test_volt_text_fmt.sv
`timescale 1ns/1ps
module test_volt_text_fmt;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [7:0] code;
  logic       out_ready;
  logic [7:0] out_char;
  logic       out_valid;
  logic       done;

  int n_cmp;
  int n_bad;
  int cyc;
  logic [7:0] exp_s [15];

  volt_text_fmt i_volt_text_fmt (
    .clk(clk), .rst_n(rst_n), .start(start), .code(code),
    .out_ready(out_ready), .out_char(out_char), .out_valid(out_valid), .done(done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input logic ok, input string req, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  task automatic build_expected(input logic [7:0] c);
    int mv, mag;
    mv  = ((int'(c) * 10000) >>> 8) - 5000;
    mag = (mv < 0) ? -mv : mv;
    exp_s[0]  = (mv < 0) ? 8'h2D : 8'h20;
    exp_s[1]  = 8'h30;
    exp_s[2]  = 8'h30 + 8'(mag / 1000);
    exp_s[3]  = 8'h2E;
    exp_s[4]  = 8'h30 + 8'((mag / 100) % 10);
    exp_s[5]  = 8'h30 + 8'((mag / 10) % 10);
    exp_s[6]  = 8'h30 + 8'(mag % 10);
    exp_s[7]  = 8'h20;
    exp_s[8]  = 8'h56;
    exp_s[9]  = 8'h6F;
    exp_s[10] = 8'h6C;
    exp_s[11] = 8'h74;
    exp_s[12] = 8'h73;
    exp_s[13] = 8'h0D;
    exp_s[14] = 8'h0A;
  endtask

  function automatic logic ready_pat(input int mode, input int k);
    case (mode)
      0:       return 1'b1;
      1:       return (k % 2) == 1;
      2:       return (k % 3) != 0;
      default: return k >= 12;
    endcase
  endfunction

  // One line: start, collect 15 bytes under a ready pattern, check done and quiet.
  task automatic run_line(input string tag, input logic [7:0] c, input int mode,
                          input logic intrude, input logic [7:0] other);
    int got, k, guard;
    logic stalled;
    logic [7:0] held;
    build_expected(c);
    @(negedge clk);
    code  = c;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (intrude) code = other;
    got = 0; k = 0; guard = 0; stalled = 1'b0; held = 8'h00;
    while (got < 15 && guard < 600) begin
      start = 1'b0;
      if (stalled)
        check(out_valid && (out_char == held), "R5 stall hold", int'(out_char), int'(held));
      check(!done, "R6 no early done", int'(done), 0);
      out_ready = ready_pat(mode, k);
      if (out_valid && out_ready) begin
        check(out_char == exp_s[got], $sformatf("R3 R2 R4 %s byte %0d", tag, got),
              int'(out_char), int'(exp_s[got]));
        got++;
        if (intrude && got == 5) begin
          start = 1'b1;
          code  = other;
        end
      end
      if (out_valid) k++;
      stalled = out_valid && !out_ready;
      held    = out_char;
      @(negedge clk);
      guard++;
    end
    start = 1'b0;
    check(got == 15, $sformatf("R3 %s byte count", tag), got, 15);
    out_ready = 1'b0;
    check(done == 1'b1, "R6 done after LF", int'(done), 1);
    check(out_valid == 1'b0, "R6 valid low at done", int'(out_valid), 0);
    @(negedge clk);
    check(done == 1'b0, "R6 done single cycle", int'(done), 0);
    for (int i = 0; i < 30; i++) begin
      if (out_valid || done) begin
        check(1'b0, $sformatf("R7 quiet after %s", tag), int'(out_valid), 0);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic test_reset();
    rst_n = 1'b0; start = 1'b0; code = 8'h00; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check(!out_valid && !done, "R1 in reset", int'({out_valid, done}), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check(!out_valid && !done, "R1 after reset", int'({out_valid, done}), 0);
  endtask

  task automatic test_latency();
    @(negedge clk);
    code = 8'hFF; start = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // Digit split needs several cycles before the first byte.
    check(!out_valid, "R8 no byte before digits", int'(out_valid), 0);
    while (!out_valid) @(negedge clk);
    while (!done) @(negedge clk);
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; cyc = 0;
    test_reset();
    run_line("min", 8'h00, 0, 1'b0, 8'h00);
    run_line("mid", 8'h80, 1, 1'b0, 8'h00);
    run_line("max", 8'hFF, 2, 1'b0, 8'h00);
    run_line("below_mid", 8'h7F, 3, 1'b0, 8'h00);
    run_line("one", 8'h01, 1, 1'b0, 8'h00);
    run_line("c3", 8'hC3, 2, 1'b0, 8'h00);
    run_line("busy_start", 8'h40, 1, 1'b1, 8'hE7);
    test_latency();
    run_line("after_busy", 8'hE7, 0, 1'b0, 8'h00);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule